// File: doc/BRIEF.md
# Deferred Floating-Point Exception Signaller

This block sits beside a floating-point unit and keeps track of arithmetic exceptions that have been detected but not yet reported to the processor. The datapath pulses a detect strobe with a vector of exception types and the address of the instruction that raised them. The block records flags, compares them against a mask register, and decides when the report is delivered. Delivery never happens at detection. It waits for a later instruction that is allowed to observe the error, and that instruction arrives through a classified instruction stream.

A mode bit selects one of two delivery styles. In native mode the block raises an internal fault request with a fixed vector number. In legacy mode it drives an active-low error pin and a stall line for external interrupt hardware, and an ignore input can silence both. A group of non-waiting control instructions never trigger a report. Some of them discard the pending report. The rest leave it in place for a later waiting instruction.

Top module: `fpx_defer_sig`

## Requirements
- R1: A detect strobe with any type bit that is not masked (mask bit 0) sets the matching `flags` bits and `es`, and records a pending report. Flag bit i stands for exception type i.
- R2: A detect strobe whose type bits are all masked (mask bit 1) sets only those flags. It leaves `es` low and produces no fault, no error pin and no stall. Reset leaves every mask bit at 1.
- R3: In native mode (`native_mode`=1) with a report pending, an instruction of class WAIT (code 1), SIMD-integer (code 2) or waiting FP (code 3) makes `fault_req` high for one cycle after that edge, with `fault_vec` = 16. Integer instructions (code 0) do nothing.
- R4: The non-waiting classes never raise `fault_req`, `err_n` or `stall`. These are initialise (4), clear-exceptions (5), store-environment (6), save-state (7), store-status (8) and store-control (9).
- R5: Initialise and clear-exceptions clear all flags, `es` and the pending report, and initialise also sets every mask bit. Store-environment and save-state set every mask bit and drop the pending report, but keep the flags and `es`.
- R6: Store-status and store-control change no state, so a pending report is still delivered by a later waiting instruction.
- R7: In legacy mode (`native_mode`=0), a detected unmasked type whose `defer_cfg` bit is 0 drives `err_n` low one cycle after the detect edge.
- R8: In legacy mode, when the pending type's `defer_cfg` bit is 1, `err_n` goes low only after a waiting FP or SIMD-integer instruction while pending. A WAIT does not drive it.
- R9: In legacy mode with a report pending, a WAIT, waiting FP or SIMD-integer instruction raises `stall` on the next cycle. `stall` then stays high.
- R10: While `ignore_err` is 1 at an edge, `err_n` is 1 and `stall` is 0 after that edge. Conditions recorded meanwhile appear once `ignore_err` returns to 0.
- R11: `fault_ip` captures `det_ip` of the first unmasked detection while nothing is pending. Later detections do not change it. It returns to 0 when the pending report is dropped.
- R12: `err_n` and `stall` are released only when `es` is cleared by initialise or clear-exceptions. Synchronous reset clears flags, `es`, pending state, `fault_ip` and the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| native_mode | input | 1 | 1 selects the internal fault, 0 selects the external pins |
| det_valid | input | 1 | Exception detect strobe |
| det_exc | input | NEXC | Detected exception types |
| det_ip | input | IPW | Address of the detecting instruction |
| mask_wr | input | 1 | Mask register write enable |
| mask_wdata | input | NEXC | New mask value, 1 = masked |
| defer_cfg | input | NEXC | Per type: 1 = defer error pin to the next waiting instruction |
| ins_valid | input | 1 | Next-instruction class is valid |
| ins_cls | input | 4 | Next-instruction class code |
| ignore_err | input | 1 | Ignore error conditions in legacy mode |
| fault_req | output | 1 | Native-mode fault request |
| fault_vec | output | 8 | Fault vector number |
| err_n | output | 1 | Active-low legacy error pin |
| stall | output | 1 | Legacy stall request |
| flags | output | NEXC | Exception flags |
| es | output | 1 | Error summary flag |
| fault_ip | output | IPW | Saved faulting-instruction address |

## Verification
The assertions assume that the instruction class code is one of the ten defined values. They also assume that `native_mode` stays constant while a report is pending, because the hold checks for `err_n` and `stall` do not model a mode change in the middle of a report. The stimulus changes mode only after a clear-exceptions has emptied the state. It applies detections and instructions in the same cycle only in cases where the order of update is defined: the discard takes effect first, then the new detection. It uses only the defined class codes.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  typedef enum logic [3:0] {
    CLS_INT    = 4'd0,
    CLS_WAIT   = 4'd1,
    CLS_SIMD   = 4'd2,
    CLS_FPW    = 4'd3,
    CLS_NINIT  = 4'd4,
    CLS_NCLEX  = 4'd5,
    CLS_NSTENV = 4'd6,
    CLS_NSAVE  = 4'd7,
    CLS_NSTSW  = 4'd8,
    CLS_NSTCW  = 4'd9
  } ins_cls_e;

  typedef struct packed {
    logic trig_any;   // WAIT, waiting FP, SIMD
    logic trig_err;   // waiting FP, SIMD
    logic discard;    // drops pending report
    logic clr_es;     // clears flags and ES
    logic mask_all;   // sets every mask bit
  } ins_dec_t;
endpackage

// File: rtl/fpx_ins_dec.sv
module fpx_ins_dec
  import fpx_pkg::*;
(
  input  logic       ins_valid,
  input  logic [3:0] ins_cls,
  output ins_dec_t   dec
);
  always_comb begin
    dec = '0;
    if (ins_valid) begin
      case (ins_cls_e'(ins_cls))
        CLS_WAIT:   dec.trig_any = 1'b1;
        CLS_SIMD, CLS_FPW: begin
          dec.trig_any = 1'b1;
          dec.trig_err = 1'b1;
        end
        CLS_NINIT: begin
          dec.discard  = 1'b1;
          dec.clr_es   = 1'b1;
          dec.mask_all = 1'b1;
        end
        CLS_NCLEX: begin
          dec.discard = 1'b1;
          dec.clr_es  = 1'b1;
        end
        CLS_NSTENV, CLS_NSAVE: begin
          dec.discard  = 1'b1;
          dec.mask_all = 1'b1;
        end
        default: dec = '0;
      endcase
    end
  end
endmodule

// File: rtl/fpx_status.sv
module fpx_status #(
  parameter int NEXC = 6,
  parameter int IPW  = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            det_valid,
  input  logic [NEXC-1:0] det_exc,
  input  logic [IPW-1:0]  det_ip,
  input  logic            mask_wr,
  input  logic [NEXC-1:0] mask_wdata,
  input  logic            discard,
  input  logic            clr_es,
  input  logic            mask_all,
  output logic [NEXC-1:0] flags,
  output logic            es,
  output logic            pend,
  output logic [NEXC-1:0] mask,
  output logic [IPW-1:0]  fault_ip
);
  logic [NEXC-1:0] flags_n, mask_n;
  logic            es_n, pend_n;
  logic [IPW-1:0]  ip_n;
  logic            unm_hit;

  assign unm_hit = det_valid && (|(det_exc & ~mask));

  always_comb begin
    flags_n = flags;
    mask_n  = mask;
    es_n    = es;
    pend_n  = pend;
    ip_n    = fault_ip;
    if (mask_wr) mask_n = mask_wdata;
    if (mask_all) mask_n = '1;
    if (clr_es) begin
      flags_n = '0;
      es_n    = 1'b0;
    end
    if (discard) begin
      pend_n = 1'b0;
      ip_n   = '0;
    end
    if (det_valid) flags_n = flags_n | det_exc;
    if (unm_hit) begin
      if (!pend_n) ip_n = det_ip;
      es_n   = 1'b1;
      pend_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags    <= '0;
      mask     <= '1;
      es       <= 1'b0;
      pend     <= 1'b0;
      fault_ip <= '0;
    end else begin
      flags    <= flags_n;
      mask     <= mask_n;
      es       <= es_n;
      pend     <= pend_n;
      fault_ip <= ip_n;
    end
  end
endmodule

// File: rtl/fpx_native.sv
module fpx_native #(
  parameter int VEC_W     = 8,
  parameter int FAULT_VEC = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             native_mode,
  input  logic             pend,
  input  logic             trig_any,
  output logic             fault_req,
  output logic [VEC_W-1:0] fault_vec
);
  localparam logic [VEC_W-1:0] VEC_VAL = VEC_W'(FAULT_VEC);
  logic fire;

  assign fire = native_mode && pend && trig_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_req <= 1'b0;
      fault_vec <= '0;
    end else begin
      fault_req <= fire;
      fault_vec <= fire ? VEC_VAL : '0;
    end
  end
endmodule

// File: rtl/fpx_legacy.sv
module fpx_legacy #(
  parameter int NEXC = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            native_mode,
  input  logic            det_valid,
  input  logic [NEXC-1:0] det_exc,
  input  logic [NEXC-1:0] mask,
  input  logic [NEXC-1:0] defer_cfg,
  input  logic            pend,
  input  logic            trig_any,
  input  logic            trig_err,
  input  logic            clr_es,
  input  logic            ignore_err,
  output logic            err_n,
  output logic            stall
);
  logic err_arm, stall_arm;
  logic err_arm_n, stall_arm_n;
  logic imm_set, dfr_set, stl_set;

  assign imm_set = !native_mode && det_valid && (|(det_exc & ~mask & ~defer_cfg));
  assign dfr_set = !native_mode && pend && trig_err;
  assign stl_set = !native_mode && pend && trig_any;

  assign err_arm_n   = (err_arm && !clr_es) || imm_set || dfr_set;
  assign stall_arm_n = (stall_arm && !clr_es) || stl_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_arm   <= 1'b0;
      stall_arm <= 1'b0;
      err_n     <= 1'b1;
      stall     <= 1'b0;
    end else begin
      err_arm   <= err_arm_n;
      stall_arm <= stall_arm_n;
      err_n     <= !(err_arm_n && !ignore_err);
      stall     <= stall_arm_n && !ignore_err;
    end
  end
endmodule

// File: rtl/fpx_defer_sig.sv
module fpx_defer_sig
  import fpx_pkg::*;
#(
  parameter int NEXC      = 6,
  parameter int IPW       = 32,
  parameter int VEC_W     = 8,
  parameter int FAULT_VEC = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             native_mode,
  input  logic             det_valid,
  input  logic [NEXC-1:0]  det_exc,
  input  logic [IPW-1:0]   det_ip,
  input  logic             mask_wr,
  input  logic [NEXC-1:0]  mask_wdata,
  input  logic [NEXC-1:0]  defer_cfg,
  input  logic             ins_valid,
  input  logic [3:0]       ins_cls,
  input  logic             ignore_err,
  output logic             fault_req,
  output logic [VEC_W-1:0] fault_vec,
  output logic             err_n,
  output logic             stall,
  output logic [NEXC-1:0]  flags,
  output logic             es,
  output logic [IPW-1:0]   fault_ip
);
  ins_dec_t        dec;
  logic            pend;
  logic [NEXC-1:0] mask_q;

  fpx_ins_dec u_dec (
    .ins_valid (ins_valid),
    .ins_cls   (ins_cls),
    .dec       (dec)
  );

  fpx_status #(.NEXC(NEXC), .IPW(IPW)) u_status (
    .clk        (clk),
    .rst        (rst),
    .det_valid  (det_valid),
    .det_exc    (det_exc),
    .det_ip     (det_ip),
    .mask_wr    (mask_wr),
    .mask_wdata (mask_wdata),
    .discard    (dec.discard),
    .clr_es     (dec.clr_es),
    .mask_all   (dec.mask_all),
    .flags      (flags),
    .es         (es),
    .pend       (pend),
    .mask       (mask_q),
    .fault_ip   (fault_ip)
  );

  fpx_native #(.VEC_W(VEC_W), .FAULT_VEC(FAULT_VEC)) u_native (
    .clk         (clk),
    .rst         (rst),
    .native_mode (native_mode),
    .pend        (pend),
    .trig_any    (dec.trig_any),
    .fault_req   (fault_req),
    .fault_vec   (fault_vec)
  );

  fpx_legacy #(.NEXC(NEXC)) u_legacy (
    .clk         (clk),
    .rst         (rst),
    .native_mode (native_mode),
    .det_valid   (det_valid),
    .det_exc     (det_exc),
    .mask        (mask_q),
    .defer_cfg   (defer_cfg),
    .pend        (pend),
    .trig_any    (dec.trig_any),
    .trig_err    (dec.trig_err),
    .clr_es      (dec.clr_es),
    .ignore_err  (ignore_err),
    .err_n       (err_n),
    .stall       (stall)
  );
endmodule

// File: rtl/fpx_defer_sig_chk.sv
module fpx_defer_sig_chk #(
  parameter int NEXC      = 6,
  parameter int IPW       = 32,
  parameter int VEC_W     = 8,
  parameter int FAULT_VEC = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             native_mode,
  input logic             det_valid,
  input logic [NEXC-1:0]  det_exc,
  input logic             ins_valid,
  input logic [3:0]       ins_cls,
  input logic             ignore_err,
  input logic             fault_req,
  input logic [VEC_W-1:0] fault_vec,
  input logic             err_n,
  input logic             stall,
  input logic             es,
  input logic             pend,
  input logic [NEXC-1:0]  mask_q,
  input logic [IPW-1:0]   fault_ip
);
  logic nonwait, drop, clr;
  assign nonwait = ins_valid && (ins_cls >= 4'd4) && (ins_cls <= 4'd9);
  assign drop    = ins_valid && (ins_cls >= 4'd4) && (ins_cls <= 4'd7);
  assign clr     = ins_valid && (ins_cls == 4'd4 || ins_cls == 4'd5);

  // R3: vector number accompanies every fault
  a_r3_fault_vec: assert property (@(posedge clk) disable iff (rst)
    fault_req |-> (fault_vec == VEC_W'(FAULT_VEC)));

  // R3: fault only follows native mode with a pending report
  a_r3_fault_cause: assert property (@(posedge clk) disable iff (rst)
    (!native_mode || !pend) |=> !fault_req);

  // R4: non-waiting classes never trigger a fault
  a_r4_nonwait_quiet: assert property (@(posedge clk) disable iff (rst)
    nonwait |=> !fault_req);

  // R1: pending report implies the summary flag
  a_r1_pend_es: assert property (@(posedge clk) disable iff (rst)
    pend |-> es);

  // R2: a fully masked detection cannot raise the summary flag
  a_r2_masked_no_es: assert property (@(posedge clk) disable iff (rst)
    (!es && (!det_valid || ((det_exc & ~mask_q) == '0))) |=> !es);

  // R7: error pin low only with the summary flag set
  a_r7_err_needs_es: assert property (@(posedge clk) disable iff (rst)
    !err_n |-> es);

  // R10: ignore input silences both legacy outputs
  a_r10_ignore: assert property (@(posedge clk) disable iff (rst)
    ignore_err |=> (err_n && !stall));

  // R12: stall holds until a clearing instruction or ignore
  a_r12_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (stall && !clr && !ignore_err) |=> stall);

  // R11: saved address is stable while the report stays pending
  a_r11_ip_hold: assert property (@(posedge clk) disable iff (rst)
    (pend && !drop) |=> $stable(fault_ip));
endmodule

bind fpx_defer_sig fpx_defer_sig_chk #(
  .NEXC(NEXC), .IPW(IPW), .VEC_W(VEC_W), .FAULT_VEC(FAULT_VEC)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .native_mode (native_mode),
  .det_valid   (det_valid),
  .det_exc     (det_exc),
  .ins_valid   (ins_valid),
  .ins_cls     (ins_cls),
  .ignore_err  (ignore_err),
  .fault_req   (fault_req),
  .fault_vec   (fault_vec),
  .err_n       (err_n),
  .stall       (stall),
  .es          (es),
  .pend        (pend),
  .mask_q      (mask_q),
  .fault_ip    (fault_ip)
);

// File: tb/fpx_defer_sig_bench.sv
`timescale 1ns/1ps
module fpx_defer_sig_bench;
  localparam int NEXC = 6;
  localparam int IPW  = 32;

  logic            clk = 1'b0;
  logic            rst;
  logic            native_mode, det_valid, mask_wr, ins_valid, ignore_err;
  logic [NEXC-1:0] det_exc, mask_wdata, defer_cfg;
  logic [IPW-1:0]  det_ip;
  logic [3:0]      ins_cls;
  logic            fault_req, err_n, stall, es;
  logic [7:0]      fault_vec;
  logic [NEXC-1:0] flags;
  logic [IPW-1:0]  fault_ip;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  fpx_defer_sig u_fpx_defer_sig (
    .clk(clk), .rst(rst), .native_mode(native_mode), .det_valid(det_valid),
    .det_exc(det_exc), .det_ip(det_ip), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .defer_cfg(defer_cfg), .ins_valid(ins_valid), .ins_cls(ins_cls),
    .ignore_err(ignore_err), .fault_req(fault_req), .fault_vec(fault_vec),
    .err_n(err_n), .stall(stall), .flags(flags), .es(es), .fault_ip(fault_ip)
  );

  // entry: req[24:17] dv[16] exc[15:10] cls[9:6] nat[5] ign[4] exp{fault,err_n,stall,es}[3:0]
  localparam int NV = 24;
  localparam logic [24:0] VECS [NV] = '{
    {8'd1,  1'b1, 6'h01, 4'd0, 1'b1, 1'b0, 4'b0101}, // R1 unmasked detect
    {8'd3,  1'b0, 6'h00, 4'd0, 1'b1, 1'b0, 4'b0101}, // R3 integer no fault
    {8'd6,  1'b0, 6'h00, 4'd8, 1'b1, 1'b0, 4'b0101}, // R6 store-status keeps
    {8'd3,  1'b0, 6'h00, 4'd3, 1'b1, 1'b0, 4'b1101}, // R3 waiting FP faults
    {8'd5,  1'b0, 6'h00, 4'd5, 1'b1, 1'b0, 4'b0100}, // R5 clear
    {8'd3,  1'b0, 6'h00, 4'd3, 1'b1, 1'b0, 4'b0100}, // R3 nothing pending
    {8'd2,  1'b1, 6'h04, 4'd0, 1'b1, 1'b0, 4'b0100}, // R2 masked detect
    {8'd2,  1'b0, 6'h00, 4'd1, 1'b1, 1'b0, 4'b0100}, // R2 WAIT no fault
    {8'd1,  1'b1, 6'h01, 4'd0, 1'b1, 1'b0, 4'b0101}, // R1
    {8'd4,  1'b0, 6'h00, 4'd9, 1'b1, 1'b0, 4'b0101}, // R4 store-control quiet
    {8'd3,  1'b0, 6'h00, 4'd2, 1'b1, 1'b0, 4'b1101}, // R3 SIMD faults
    {8'd5,  1'b0, 6'h00, 4'd5, 1'b1, 1'b0, 4'b0100}, // R5 clear
    {8'd7,  1'b1, 6'h01, 4'd0, 1'b0, 1'b0, 4'b0001}, // R7 immediate pin
    {8'd9,  1'b0, 6'h00, 4'd1, 1'b0, 1'b0, 4'b0011}, // R9 WAIT stalls
    {8'd9,  1'b0, 6'h00, 4'd0, 1'b0, 1'b0, 4'b0011}, // R9 held
    {8'd12, 1'b0, 6'h00, 4'd5, 1'b0, 1'b0, 4'b0100}, // R12 release
    {8'd8,  1'b1, 6'h02, 4'd0, 1'b0, 1'b0, 4'b0101}, // R8 deferred type
    {8'd8,  1'b0, 6'h00, 4'd1, 1'b0, 1'b0, 4'b0111}, // R8 WAIT no pin
    {8'd8,  1'b0, 6'h00, 4'd3, 1'b0, 1'b0, 4'b0011}, // R8 waiting FP pin
    {8'd12, 1'b0, 6'h00, 4'd5, 1'b0, 1'b0, 4'b0100}, // R12 release
    {8'd10, 1'b1, 6'h01, 4'd0, 1'b0, 1'b1, 4'b0101}, // R10 ignored
    {8'd10, 1'b0, 6'h00, 4'd3, 1'b0, 1'b1, 4'b0101}, // R10 ignored stall
    {8'd10, 1'b0, 6'h00, 4'd0, 1'b0, 1'b0, 4'b0011}, // R10 resumes
    {8'd12, 1'b0, 6'h00, 4'd5, 1'b0, 1'b0, 4'b0100}  // R12 release
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input bit dv, input logic [NEXC-1:0] ex, input logic [3:0] cls,
                     input bit nat, input bit ign, input logic [IPW-1:0] ip);
    det_valid = dv; det_exc = ex; ins_cls = cls; native_mode = nat;
    ignore_err = ign; det_ip = ip; ins_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_mask(input logic [NEXC-1:0] m);
    mask_wr = 1'b1; mask_wdata = m;
    put(1'b0, '0, 4'd0, 1'b1, 1'b0, '0);
    mask_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; native_mode = 1'b1; det_valid = 1'b0; det_exc = '0; det_ip = '0;
    mask_wr = 1'b0; mask_wdata = '0; defer_cfg = 6'b000010; ins_valid = 1'b0;
    ins_cls = 4'd0; ignore_err = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    check({fault_req, err_n, stall, es} == 4'b0100, "R12", {fault_req, err_n, stall, es}, 4'b0100);
    check(flags == '0 && fault_ip == '0, "R12", flags, 0);
    // R2 reset mask: all masked
    put(1'b1, 6'h01, 4'd0, 1'b1, 1'b0, '0);
    check(es == 1'b0 && flags == 6'h01, "R2", {es, flags}, 7'h01);
    put(1'b0, '0, 4'd5, 1'b1, 1'b0, '0);
    set_mask(6'b111100);

    for (int i = 0; i < NV; i++) begin
      put(VECS[i][16], VECS[i][15:10], VECS[i][9:6], VECS[i][5], VECS[i][4], '0);
      checks++;
      if ({fault_req, err_n, stall, es} != VECS[i][3:0]) begin
        fails++;
        $display("FAIL R%0d row %0d actual=%b expected=%b", VECS[i][24:17], i,
                 {fault_req, err_n, stall, es}, VECS[i][3:0]);
      end
    end

    // R11 first address kept
    put(1'b1, 6'h01, 4'd0, 1'b1, 1'b0, 32'h1234);
    check(fault_ip == 32'h1234, "R11", fault_ip, 32'h1234);
    put(1'b1, 6'h02, 4'd0, 1'b1, 1'b0, 32'h5678);
    check(fault_ip == 32'h1234, "R11", fault_ip, 32'h1234);
    check(flags == 6'h03, "R1", flags, 6'h03);
    put(1'b0, '0, 4'd3, 1'b1, 1'b0, '0);
    check(fault_req && fault_vec == 8'd16, "R3", fault_vec, 16);
    put(1'b0, '0, 4'd5, 1'b1, 1'b0, '0);
    check(fault_ip == '0 && flags == '0, "R11", fault_ip, 0);

    // R5 store-environment discards by masking
    put(1'b1, 6'h01, 4'd0, 1'b1, 1'b0, '0);
    put(1'b0, '0, 4'd6, 1'b1, 1'b0, '0);
    check(es && flags == 6'h01, "R5", {es, flags}, 7'h41);
    put(1'b0, '0, 4'd3, 1'b1, 1'b0, '0);
    check(!fault_req, "R5", fault_req, 0);
    put(1'b0, '0, 4'd5, 1'b1, 1'b0, '0);
    set_mask(6'b111100);

    // R5 initialise clears and masks all
    put(1'b1, 6'h01, 4'd0, 1'b1, 1'b0, '0);
    put(1'b0, '0, 4'd4, 1'b1, 1'b0, '0);
    check(!es && flags == '0, "R5", {es, flags}, 0);
    put(1'b1, 6'h01, 4'd0, 1'b1, 1'b0, '0);
    check(!es && flags == 6'h01, "R5", {es, flags}, 7'h01);
    put(1'b0, '0, 4'd5, 1'b1, 1'b0, '0);
    set_mask(6'b111100);

    // R12 reset mid-report
    put(1'b1, 6'h01, 4'd0, 1'b0, 1'b0, '0);
    check(!err_n, "R7", err_n, 0);
    rst = 1'b1;
    put(1'b0, '0, 4'd0, 1'b0, 1'b0, '0);
    rst = 1'b0;
    check(err_n && !stall && !es && flags == '0, "R12", {err_n, stall, es}, 3'b100);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule